// File: doc/BRIEF.md
# Lockable Register Preload and Readback Controller

This block is the test-access front end for the bank of output state registers in a small programmable logic device. A tester drives commands through a valid/ready port. It can force any single state register high or low (preload), read back words of the stored configuration pattern (verify), and stream out a 64-bit user signature. Every command ends in a response beat that carries data, an error flag and a last-beat marker.

A sticky lock bit protects the configuration. A LOCK command sets it, and from the very next accepted command on, verify and preload are refused. The signature stays readable while the lock is set. Only a full ERASE clears the lock, and ERASE also fills the configuration pattern with ones.

After power-up reset, all state registers are low, so the inverted register outputs are high. For a programmable number of cycles after reset the block ignores clock-driven updates: both the command port and the functional load path are held off.

Top module: `regbank_test_ctrl`

## Requirements
- R1: During and right after reset, every state register is low, so `q_n` is all ones, `rsp_valid` is low and the lock is clear. Configuration word i holds the low 8 bits of (i*29) xor 0x5A.
- R2: For the first PR_CYCLES clock edges after reset is released, `cmd_ready` is low and `func_en` has no effect on `q_n`. On the edge after that, `cmd_ready` rises.
- R3: Outside the hold interval, `func_en` high loads `func_d` into the state registers at the clock edge, and `q_n` shows the inverse of the registers.
- R4: Opcode 0 (PRELOAD) with `cmd_addr` below NUM_REGS writes `cmd_value` into register `cmd_addr` only, at the accepting edge. It answers one cycle later with data 0, error 0 and last 1. In the same cycle it takes priority over `func_d` for that bit.
- R5: A PRELOAD with `cmd_addr` of NUM_REGS or more answers with error 1 and changes no register.
- R6: Opcode 1 (VERIFY) answers one cycle after acceptance with configuration word `cmd_addr`, error 0 and last 1.
- R7: Opcode 2 (READSIG) holds `cmd_ready` low and, starting two cycles after acceptance, returns eight consecutive beats with the least significant byte of the signature first and `rsp_last` on the eighth beat. This happens whether or not the lock is set.
- R8: Opcode 3 (LOCK) sets the lock and is acknowledged with error 0. A command accepted in the very next cycle already sees the lock. The lock stays set until an ERASE.
- R9: While locked, VERIFY answers with data 0 and error 1, and PRELOAD answers with error 1 and leaves every register unchanged.
- R10: Opcode 4 (ERASE) clears the lock, sets every configuration word to all ones, and is acknowledged with error 0.
- R11: Opcodes 5 to 7 answer with error 1 and data 0 and change nothing. Any error response is a single beat with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| func_en | input | 1 | Load functional next state into the registers |
| func_d | input | NUM_REGS | Functional next state |
| q_n | output | NUM_REGS | Inverted register outputs |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | ADDR_W | Register index or configuration word index |
| cmd_value | input | 1 | Preload value |
| rsp_valid | output | 1 | Response beat valid |
| rsp_data | output | DATA_W | Response data |
| rsp_err | output | 1 | Command refused or illegal |
| rsp_last | output | 1 | Final beat of the response |

## Verification
Preload is tried on single bits while a functional load happens in the same cycle, which separates a per-bit override from a whole-word write. It is also tried with an out-of-range index and while locked, which separates refusal from a silent write. Verify runs over every configuration word after reset and again after erase, which tells the computed initial pattern apart from the erased one. A LOCK followed back-to-back by VERIFY shows that the lock takes effect at once. A long seeded random mix of all eight opcodes, against a bench model of registers, lock and pattern, exercises orderings such as signature reads while locked and erase followed by preload.

// File: rtl/tac_pkg.sv
package tac_pkg;

    typedef enum logic [2:0] {
        OP_PRELOAD = 3'd0,
        OP_VERIFY  = 3'd1,
        OP_READSIG = 3'd2,
        OP_LOCK    = 3'd3,
        OP_ERASE   = 3'd4
    } tac_op_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SIG  = 1'b1
    } tac_phase_e;

endpackage

// File: rtl/tac_hold_timer.sv
module tac_hold_timer #(
    parameter int PR_CYCLES = 150
) (
    input  logic clk,
    input  logic rst_n,
    output logic hold
);
    localparam int CW = $clog2(PR_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q < CW'(PR_CYCLES)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hold = (cnt_q < CW'(PR_CYCLES));
endmodule

// File: rtl/tac_cfg_store.sv
module tac_cfg_store #(
    parameter int WORDS  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = erase ? '1 : mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= DATA_W'((i * 29) ^ 32'h5A);
            end
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/tac_sig_mux.sv
module tac_sig_mux #(
    parameter int          SIG_WIDTH = 64,
    parameter int          DATA_W    = 8,
    parameter logic [63:0] SIG_VALUE = 64'h0123_4567_89AB_CDEF
) (
    input  logic [$clog2(SIG_WIDTH/DATA_W)-1:0] beat,
    output logic [DATA_W-1:0]                   byte_out
);
    localparam int BEATS = SIG_WIDTH / DATA_W;

    logic [DATA_W-1:0] lanes [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        assign lanes[g] = SIG_VALUE[g*DATA_W +: DATA_W];
    end

    assign byte_out = lanes[beat];
endmodule

// File: rtl/regbank_test_ctrl.sv
module regbank_test_ctrl
    import tac_pkg::*;
#(
    parameter int          NUM_REGS  = 8,
    parameter int          CFG_WORDS = 16,
    parameter int          ADDR_W    = 4,
    parameter int          DATA_W    = 8,
    parameter int          PR_CYCLES = 150,
    parameter int          SIG_WIDTH = 64,
    parameter logic [63:0] SIG_VALUE = 64'h0123_4567_89AB_CDEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                func_en,
    input  logic [NUM_REGS-1:0] func_d,
    output logic [NUM_REGS-1:0] q_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [2:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                cmd_value,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                rsp_err,
    output logic                rsp_last
);
    localparam int SIG_BEATS = SIG_WIDTH / DATA_W;
    localparam int BEAT_W    = $clog2(SIG_BEATS);

    typedef struct packed {
        tac_phase_e          phase;
        logic [BEAT_W-1:0]   beat;
        logic                lock;
        logic [NUM_REGS-1:0] regs;
        logic                rsp_valid;
        logic [DATA_W-1:0]   rsp_data;
        logic                rsp_err;
        logic                rsp_last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              hold_w;
    logic              erase_w;
    logic              accept_w;
    logic [DATA_W-1:0] cfg_word_w;
    logic [DATA_W-1:0] sig_byte_w;

    tac_hold_timer #(.PR_CYCLES(PR_CYCLES)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold_w)
    );

    tac_cfg_store #(
        .WORDS  (CFG_WORDS),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase_w),
        .rd_addr (cmd_addr),
        .rd_data (cfg_word_w)
    );

    tac_sig_mux #(
        .SIG_WIDTH (SIG_WIDTH),
        .DATA_W    (DATA_W),
        .SIG_VALUE (SIG_VALUE)
    ) u_sig (
        .beat     (ctl_q.beat),
        .byte_out (sig_byte_w)
    );

    assign cmd_ready = !hold_w && (ctl_q.phase == PH_IDLE);
    assign accept_w  = cmd_valid && cmd_ready;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        ctl_d.rsp_data  = '0;
        ctl_d.rsp_err   = 1'b0;
        ctl_d.rsp_last  = 1'b0;
        erase_w         = 1'b0;

        // Functional load first; a preload in the same cycle overrides its bit.
        if (func_en && !hold_w) begin
            ctl_d.regs = func_d;
        end

        if (ctl_q.phase == PH_SIG) begin
            ctl_d.rsp_valid = 1'b1;
            ctl_d.rsp_data  = sig_byte_w;
            if (ctl_q.beat == BEAT_W'(SIG_BEATS - 1)) begin
                ctl_d.rsp_last = 1'b1;
                ctl_d.phase    = PH_IDLE;
                ctl_d.beat     = '0;
            end else begin
                ctl_d.beat = ctl_q.beat + 1'b1;
            end
        end else if (accept_w) begin
            case (tac_op_e'(cmd_op))
                OP_PRELOAD: begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_last  = 1'b1;
                    if (ctl_q.lock || (int'(cmd_addr) >= NUM_REGS)) begin
                        ctl_d.rsp_err = 1'b1;
                    end else begin
                        for (int i = 0; i < NUM_REGS; i++) begin
                            if (cmd_addr == ADDR_W'(i)) begin
                                ctl_d.regs[i] = cmd_value;
                            end
                        end
                    end
                end
                OP_VERIFY: begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_last  = 1'b1;
                    if (ctl_q.lock) begin
                        ctl_d.rsp_err = 1'b1;
                    end else begin
                        ctl_d.rsp_data = cfg_word_w;
                    end
                end
                OP_READSIG: begin
                    ctl_d.phase = PH_SIG;
                    ctl_d.beat  = '0;
                end
                OP_LOCK: begin
                    ctl_d.lock      = 1'b1;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_last  = 1'b1;
                end
                OP_ERASE: begin
                    ctl_d.lock      = 1'b0;
                    erase_w         = 1'b1;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_last  = 1'b1;
                end
                default: begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_last  = 1'b1;
                    ctl_d.rsp_err   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, beat: '0, lock: 1'b0, regs: '0,
                       rsp_valid: 1'b0, rsp_data: '0, rsp_err: 1'b0,
                       rsp_last: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign q_n       = ~ctl_q.regs;
    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_data  = ctl_q.rsp_data;
    assign rsp_err   = ctl_q.rsp_err;
    assign rsp_last  = ctl_q.rsp_last;
endmodule

// File: rtl/regbank_test_ctrl_chk.sv
module regbank_test_ctrl_chk
    import tac_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hold,
    input logic                lock,
    input logic                accept,
    input logic [2:0]          op,
    input logic                func_en,
    input logic [NUM_REGS-1:0] q_n,
    input logic                cmd_ready,
    input logic                rsp_valid,
    input logic [DATA_W-1:0]   rsp_data,
    input logic                rsp_err,
    input logic                rsp_last
);
    AST_RESET_OUTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((&q_n) && !rsp_valid && !lock)); // R1

    AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !cmd_ready); // R2

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q_n)); // R2

    AST_SIG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_READSIG) |=> (!rsp_valid && !cmd_ready)); // R7

    AST_LOCK_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_LOCK) |=> lock); // R8

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !(accept && op == OP_ERASE)) |=> lock); // R8

    AST_LOCKED_VERIFY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_VERIFY && lock) |=> (rsp_valid && rsp_err && rsp_data == '0)); // R9

    AST_LOCKED_PRELOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PRELOAD && lock && !func_en) |=> $stable(q_n)); // R9

    AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_ERASE) |=> !lock); // R10

    AST_ERR_SINGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_last && rsp_data == '0)); // R11
endmodule

bind regbank_test_ctrl regbank_test_ctrl_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold_w),
    .lock      (ctl_q.lock),
    .accept    (accept_w),
    .op        (cmd_op),
    .func_en   (func_en),
    .q_n       (q_n),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .rsp_last  (rsp_last)
);

// File: tb/sim_regbank_test_ctrl.sv
`timescale 1ns/1ps
module sim_regbank_test_ctrl;
    localparam int          NR   = 8;
    localparam int          NW   = 16;
    localparam int          AW   = 4;
    localparam int          DW   = 8;
    localparam int          PRC  = 150;
    localparam logic [63:0] SIG  = 64'h0123_4567_89AB_CDEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          func_en = 1'b0;
    logic [NR-1:0] func_d = '0;
    logic [NR-1:0] q_n;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_value = 1'b0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_err;
    logic          rsp_last;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [NR-1:0] m_regs;
    logic          m_lock;
    logic [DW-1:0] m_cfg [NW];
    logic [DW+1:0] rq [$];

    always #2 clk = ~clk;

    regbank_test_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .func_en(func_en), .func_d(func_d), .q_n(q_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_value(cmd_value), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_err(rsp_err), .rsp_last(rsp_last)
    );

    always @(negedge clk) begin
        if (rst_n && rsp_valid) rq.push_back({rsp_last, rsp_err, rsp_data});
    end

    function automatic logic [DW-1:0] init_word(int i);
        return DW'((i * 29) ^ 32'h5A);
    endfunction

    function automatic logic [DW-1:0] sig_byte(int k);
        return SIG[k*8 +: 8];
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(logic [2:0] op, logic [AW-1:0] addr, logic val);
        @(negedge clk);
        cmd_op = op; cmd_addr = addr; cmd_value = val; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #0.5 cmd_valid = 1'b0;
    endtask

    task automatic get_rsp(output logic [DW+1:0] r);
        while (rq.size() == 0) @(posedge clk);
        r = rq.pop_front();
    endtask

    function automatic string op_tag(logic [2:0] op, logic [AW-1:0] addr);
        case (op)
            3'd0: return m_lock ? "R9 locked preload" : (int'(addr) >= NR ? "R5 preload range" : "R4 preload");
            3'd1: return m_lock ? "R9 locked verify" : "R6 verify";
            3'd2: return "R7 signature";
            3'd3: return "R8 lock ack";
            3'd4: return "R10 erase ack";
            default: return "R11 illegal opcode";
        endcase
    endfunction

    task automatic do_cmd(logic [2:0] op, logic [AW-1:0] addr, logic val);
        logic [DW+1:0] r, e;
        string tag;
        tag = op_tag(op, addr);
        send(op, addr, val);
        if (op == 3'd2) begin
            for (int k = 0; k < 8; k++) begin
                get_rsp(r);
                e = {(k == 7), 1'b0, sig_byte(k)};
                chk(r == e, tag, r, e);
            end
        end else begin
            e = {1'b1, 1'b0, {DW{1'b0}}};
            case (op)
                3'd0: if (m_lock || int'(addr) >= NR) e[DW] = 1'b1;
                      else m_regs[addr[2:0]] = val;
                3'd1: if (m_lock) e[DW] = 1'b1; else e[DW-1:0] = m_cfg[addr];
                3'd3: m_lock = 1'b1;
                3'd4: begin
                    m_lock = 1'b0;
                    for (int i = 0; i < NW; i++) m_cfg[i] = '1;
                end
                default: e[DW] = 1'b1;
            endcase
            get_rsp(r);
            chk(r == e, tag, r, e);
        end
        chk(q_n == ~m_regs, {tag, " regs"}, q_n, ~m_regs);
    endtask

    initial begin
        logic [DW+1:0] r;
        void'($urandom(32'd2024));
        m_regs = '0; m_lock = 1'b0;
        for (int i = 0; i < NW; i++) m_cfg[i] = init_word(i);

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(q_n == '1, "R1 reset q_n", q_n, '1);
        chk(!rsp_valid, "R1 reset rsp_valid", rsp_valid, 0);
        // Release reset with a functional load pending; hold must mask it.
        func_en = 1'b1; func_d = '1;
        rst_n = 1'b1;
        repeat (PRC - 1) @(posedge clk);
        @(negedge clk);
        chk(!cmd_ready, "R2 ready low at end of hold", cmd_ready, 0);
        chk(q_n == '1, "R2 func ignored in hold", q_n, '1);
        func_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(cmd_ready, "R2 ready after hold", cmd_ready, 1);
        chk(q_n == '1, "R2 regs still low", q_n, '1);

        for (int i = 0; i < NW; i++) do_cmd(3'd1, AW'(i), 1'b0); // R1 R6 initial pattern

        // R3 functional load
        @(negedge clk);
        func_en = 1'b1; func_d = 8'h3C;
        @(posedge clk);
        @(negedge clk);
        func_en = 1'b0;
        m_regs = 8'h3C;
        chk(q_n == ~8'h3C, "R3 functional load", q_n, ~8'h3C);

        // R4 preload overrides functional load on the same bit
        func_en = 1'b1; func_d = 8'h00;
        m_regs = 8'h00;
        do_cmd(3'd0, 4'd5, 1'b1);
        func_en = 1'b0;
        chk(q_n == ~8'h20, "R4 preload over func", q_n, ~8'h20);
        do_cmd(3'd0, 4'd0, 1'b1);
        do_cmd(3'd0, 4'd5, 1'b0);
        do_cmd(3'd0, 4'd9, 1'b1);   // R5
        do_cmd(3'd0, 4'd15, 1'b0);  // R5
        do_cmd(3'd2, 4'd0, 1'b0);   // R7 unlocked
        do_cmd(3'd6, 4'd1, 1'b1);   // R11

        // R8 lock takes effect on the very next accepted command
        send(3'd3, 4'd0, 1'b0);
        send(3'd1, 4'd2, 1'b0);
        m_lock = 1'b1;
        get_rsp(r);
        chk(r == {2'b10, 8'h00}, "R8 lock ack", r, {2'b10, 8'h00});
        get_rsp(r);
        chk(r == {2'b11, 8'h00}, "R8 R9 verify right after lock", r, {2'b11, 8'h00});
        do_cmd(3'd0, 4'd3, 1'b1);   // R9
        do_cmd(3'd2, 4'd0, 1'b0);   // R7 locked
        do_cmd(3'd3, 4'd0, 1'b0);   // R8 relock
        do_cmd(3'd4, 4'd0, 1'b0);   // R10
        do_cmd(3'd1, 4'd3, 1'b0);   // R10 erased word
        do_cmd(3'd0, 4'd3, 1'b1);   // R10 preload allowed again

        for (int n = 0; n < 400; n++) begin
            int sel;
            logic [2:0] op;
            sel = $urandom % 20;
            if (sel < 8) op = 3'd0;
            else if (sel < 12) op = 3'd1;
            else if (sel < 14) op = 3'd2;
            else if (sel < 15) op = 3'd3;
            else if (sel < 17) op = 3'd4;
            else op = 3'(5 + ($urandom % 3));
            do_cmd(op, AW'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule